// File: doc/BRIEF.md
# Single-Bit and Scaled-Index Arithmetic Unit

This block is a purely combinational execution slice for a 64-bit integer datapath. It handles two families of operations. The first family works on one bit of the first operand: it can force that bit to one, force it to zero, flip it, or return it alone as the result. The bit is picked either by the low six bits of the second operand or by a six-bit immediate. The second family produces addresses: it scales the first operand by 2, 4 or 8 and adds the second operand. Word-unsigned variants first take only the low 32 bits of the first operand as an unsigned value. An unsigned-word add and an immediate left shift of a zero-extended word are also part of this family.

Each family has its own enable input. The word-unsigned forms also need the 64-bit mode input. Any operation that is not allowed, and any unassigned operation code, raises `illegal_o` and drives a zero result. Instruction decode and register-file access sit outside this block.

Top module: `bitscale_unit`

## Requirements
- R1: Operation code 0 (set) returns `src_a_i` with the bit at the selected index forced to 1.
- R2: Operation code 1 (clear) returns `src_a_i` with the bit at the selected index forced to 0.
- R3: Operation code 2 (invert) returns `src_a_i` with the bit at the selected index complemented.
- R4: Operation code 3 (extract) returns the bit of `src_a_i` at the selected index in result bit 0, with all other result bits 0.
- R5: The selected index is `imm_i` when `use_imm_i` is 1, and otherwise bits 5:0 of `src_b_i`; bits 63:6 of `src_b_i` have no effect on the single-bit operations. Both index sources give the same result for the same index value.
- R6: Operation codes 4, 5 and 6 return `(src_a_i << k) + src_b_i` for k = 1, 2 and 3 respectively, modulo 2^64.
- R7: Operation codes 7, 8 and 9 return `(zext32(src_a_i) << k) + src_b_i` for k = 1, 2 and 3, modulo 2^64. Bits 63:32 of `src_a_i` have no effect.
- R8: Operation code 10 returns `zext32(src_a_i) + src_b_i` modulo 2^64.
- R9: Operation code 11 returns `zext32(src_a_i) << imm_i`, truncated to 64 bits, so at most 64 minus `imm_i` source bits survive.
- R10: Codes 0 to 3 with `bit_en_i` = 0, or codes 4 to 11 with `addr_en_i` = 0, set `illegal_o` = 1 and result 0.
- R11: Codes 7 to 11 with `mode64_i` = 0 set `illegal_o` = 1 and result 0. Codes 0 to 6 do not depend on `mode64_i`.
- R12: Codes 12 to 15 always set `illegal_o` = 1 and result 0. Every legal operation drives `illegal_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| src_a_i | input | 64 | First operand |
| src_b_i | input | 64 | Second operand, also the register bit index |
| imm_i | input | 6 | Immediate bit index or shift amount |
| use_imm_i | input | 1 | Take the bit index from `imm_i` |
| bit_en_i | input | 1 | Enables the single-bit family |
| addr_en_i | input | 1 | Enables the scaled-add family |
| mode64_i | input | 1 | 64-bit mode, needed by word-unsigned forms |
| result_o | output | 64 | Operation result |
| illegal_o | output | 1 | Operation rejected |

## Verification
Random operands with all sixteen codes and random enable, mode and index-source settings are compared against a bench model. This shows whether each code routes to the right function and whether each rejection cause acts on its own. Directed cases use index 0 and 63 and a second operand whose upper bits are all ones. They separate a correct six-bit index from one that reads too wide, or from a shift that drops the edge bits. Operands with the upper word set show whether the word-unsigned forms really discard those bits. All-ones sums show that the adds wrap, and an immediate shift of 40 shows whether the shifted-out bits are truncated.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int XLEN  = 64;
  localparam int WORDW = 32;
  localparam int IDXW  = $clog2(XLEN);
  localparam int OPW   = 4;

  typedef enum logic [OPW-1:0] {
    OP_BSET   = 4'd0,
    OP_BCLR   = 4'd1,
    OP_BINV   = 4'd2,
    OP_BEXT   = 4'd3,
    OP_SC1    = 4'd4,
    OP_SC2    = 4'd5,
    OP_SC3    = 4'd6,
    OP_SC1W   = 4'd7,
    OP_SC2W   = 4'd8,
    OP_SC3W   = 4'd9,
    OP_ADDW   = 4'd10,
    OP_SLLW   = 4'd11
  } bsu_op_e;

  function automatic logic is_bit_op(input logic [OPW-1:0] op);
    return op <= OP_BEXT;
  endfunction

  function automatic logic is_addr_op(input logic [OPW-1:0] op);
    return (op >= OP_SC1) && (op <= OP_SLLW);
  endfunction

  function automatic logic is_word_op(input logic [OPW-1:0] op);
    return (op >= OP_SC1W) && (op <= OP_SLLW);
  endfunction
endpackage

// File: rtl/bsu_single_bit.sv
module bsu_single_bit
  import bsu_pkg::*;
#(
  parameter int W  = XLEN,
  localparam int IW = $clog2(W)
) (
  input  logic [1:0]    sel_i,
  input  logic [W-1:0]  val_i,
  input  logic [IW-1:0] idx_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0] onehot;

  always_comb begin
    onehot = {{(W-1){1'b0}}, 1'b1} << idx_i;
    unique case (sel_i)
      2'd0:    res_o = val_i | onehot;
      2'd1:    res_o = val_i & ~onehot;
      2'd2:    res_o = val_i ^ onehot;
      default: res_o = {{(W-1){1'b0}}, val_i[idx_i]};
    endcase
  end

  always_comb begin
    if (sel_i == 2'd0) a_r1_bit_set: assert (res_o[idx_i] == 1'b1);
    if (sel_i == 2'd1) a_r2_bit_clear: assert (res_o[idx_i] == 1'b0);
    if (sel_i <= 2'd1) a_r1_one_bit_touched: assert ($countones(res_o ^ val_i) <= 1);
    if (sel_i == 2'd2) a_r3_exactly_one_flip: assert ($countones(res_o ^ val_i) == 1);
    if (sel_i == 2'd3) a_r4_upper_zero: assert (res_o[W-1:1] == '0);
  end
endmodule

// File: rtl/bsu_shift_add.sv
module bsu_shift_add
  import bsu_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int WW = WORDW,
  localparam int IW = $clog2(W),
  localparam int NSCALE = 4
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [IW-1:0]  sh_i,
  output logic [W-1:0]   res_o
);
  logic [W-1:0] a_word;
  logic [W-1:0] base;
  logic [W-1:0] scaled [NSCALE];
  logic [1:0]   scale;
  logic         word_src;

  assign a_word = {{(W-WW){1'b0}}, a_i[WW-1:0]};

  always_comb begin
    word_src = is_word_op(op_i);
    unique case (op_i)
      OP_SC1, OP_SC1W: scale = 2'd1;
      OP_SC2, OP_SC2W: scale = 2'd2;
      OP_SC3, OP_SC3W: scale = 2'd3;
      default:         scale = 2'd0;
    endcase
  end

  assign base = word_src ? a_word : a_i;

  for (genvar k = 0; k < NSCALE; k++) begin : g_scale
    assign scaled[k] = base << k;
  end

  always_comb begin
    if (op_i == OP_SLLW) res_o = a_word << sh_i;
    else                 res_o = scaled[scale] + b_i;
  end

  always_comb begin
    if (op_i == OP_ADDW) a_r8_word_add: assert (((res_o - b_i) >> WW) == '0);
    if (op_i == OP_SC3W) a_r7_word_scale: assert (((res_o - b_i) >> (WW + 3)) == '0);
    if (op_i == OP_SLLW) a_r9_low_zero: assert ((res_o & ~({W{1'b1}} << sh_i)) == '0);
  end
endmodule

// File: rtl/bitscale_unit.sv
module bitscale_unit
  import bsu_pkg::*;
#(
  parameter int W  = XLEN,
  localparam int IW = $clog2(W)
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   src_a_i,
  input  logic [W-1:0]   src_b_i,
  input  logic [IW-1:0]  imm_i,
  input  logic           use_imm_i,
  input  logic           bit_en_i,
  input  logic           addr_en_i,
  input  logic           mode64_i,
  output logic [W-1:0]   result_o,
  output logic           illegal_o
);
  logic [IW-1:0] bit_idx;
  logic [W-1:0]  bit_res;
  logic [W-1:0]  addr_res;
  logic          grp_bit, grp_addr, ok;

  assign bit_idx = use_imm_i ? imm_i : src_b_i[IW-1:0];

  bsu_single_bit #(.W(W)) u_bit (
    .sel_i (op_i[1:0]),
    .val_i (src_a_i),
    .idx_i (bit_idx),
    .res_o (bit_res)
  );

  bsu_shift_add #(.W(W)) u_addr (
    .op_i  (op_i),
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .sh_i  (imm_i),
    .res_o (addr_res)
  );

  always_comb begin
    grp_bit  = is_bit_op(op_i);
    grp_addr = is_addr_op(op_i);
    ok = (grp_bit && bit_en_i) ||
         (grp_addr && addr_en_i && (mode64_i || !is_word_op(op_i)));
    illegal_o = !ok;
    if (!ok)          result_o = '0;
    else if (grp_bit) result_o = bit_res;
    else              result_o = addr_res;
  end

  always_comb begin
    if (illegal_o) a_r10_reject_zero: assert (result_o == '0);
    if (op_i >= 4'd12) a_r12_unassigned: assert (illegal_o);
    if (is_word_op(op_i) && !mode64_i) a_r11_word_needs_mode: assert (illegal_o);
  end
endmodule

// File: tb/bitscale_unit_test.sv
module bitscale_unit_test;
  logic        clk;
  logic [3:0]  op;
  logic [63:0] a, b, res;
  logic [5:0]  imm;
  logic        use_imm, ben, aen, m64, ill;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;

  bitscale_unit uut (
    .op_i(op), .src_a_i(a), .src_b_i(b), .imm_i(imm), .use_imm_i(use_imm),
    .bit_en_i(ben), .addr_en_i(aen), .mode64_i(m64),
    .result_o(res), .illegal_o(ill)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic logic model_ill(input logic [3:0] o, input logic be, ae, m);
    if (o <= 4'd3) return !be;
    if (o <= 4'd6) return !ae;
    if (o <= 4'd11) return !(ae && m);
    return 1'b1;
  endfunction

  function automatic logic [63:0] model_res(input logic [3:0] o, input logic [63:0] x, y,
                                            input logic [5:0] im, input logic ui,
                                            input logic be, ae, m);
    int idx;
    logic [63:0] xw, r;
    if (model_ill(o, be, ae, m)) return 64'd0;
    idx = ui ? int'(im) : int'(y[5:0]);
    xw = {32'd0, x[31:0]};
    r = x;
    case (o)
      4'd0: r[idx] = 1'b1;
      4'd1: r[idx] = 1'b0;
      4'd2: r[idx] = ~x[idx];
      4'd3: r = 64'(x[idx]);
      4'd4: r = x * 64'd2 + y;
      4'd5: r = x * 64'd4 + y;
      4'd6: r = x * 64'd8 + y;
      4'd7: r = xw * 64'd2 + y;
      4'd8: r = xw * 64'd4 + y;
      4'd9: r = xw * 64'd8 + y;
      4'd10: r = xw + y;
      default: begin
        r = '0;
        for (int i = 0; i < 32; i++) if (i + int'(im) < 64) r[i + int'(im)] = x[i];
      end
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [3:0] o, input logic be, ae, m);
    if (o >= 4'd12) return "R12";
    if (o <= 4'd3 && !be) return "R10";
    if (o >= 4'd4 && !ae) return "R10";
    if (o >= 4'd7 && !m) return "R11";
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5, 4'd6: return "R6";
      4'd7, 4'd8, 4'd9: return "R7";
      4'd10: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [63:0] x, y, input logic [5:0] im,
                       input logic ui, be, ae, m, input string tag);
    logic [63:0] er;
    logic        ei;
    string       rq;
    @(posedge clk);
    op = o; a = x; b = y; imm = im; use_imm = ui; ben = be; aen = ae; m64 = m;
    @(negedge clk);
    er = model_res(o, x, y, im, ui, be, ae, m);
    ei = model_ill(o, be, ae, m);
    rq = (tag != "") ? tag : req_of(o, be, ae, m);
    n_chk++;
    if (res !== er) begin
      n_bad++;
      $display("FAIL %s result op=%0d actual=%h expected=%h", rq, o, res, er);
    end
    n_chk++;
    if (ill !== ei) begin
      n_bad++;
      $display("FAIL %s illegal op=%0d actual=%b expected=%b", rq, o, ill, ei);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] seed_dummy;
    op = 4'd15; a = '0; b = '0; imm = '0; use_imm = 0; ben = 0; aen = 0; m64 = 0;
    seed_dummy = 64'($urandom(32'd7215));
    // reset-state style check: all disabled, unassigned code
    apply(4'd15, 64'hFFFF, 64'h1, 6'd0, 0, 0, 0, 0, "R12");
    // R1 R2 R3 R4 edge indices
    apply(4'd0, 64'd0, 64'd63, 6'd0, 0, 1, 0, 0, "R1");
    apply(4'd1, '1, 64'd0, 6'd0, 0, 1, 0, 0, "R2");
    apply(4'd2, 64'hA5A5_0000_FFFF_1234, 64'd0, 6'd63, 1, 1, 0, 0, "R3");
    apply(4'd3, 64'h8000_0000_0000_0000, 64'd0, 6'd63, 1, 1, 0, 1, "R4");
    // R5 upper bits of index operand ignored, imm and reg forms agree
    apply(4'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFC5, 6'd0, 0, 1, 1, 1, "R5");
    apply(4'd0, 64'd0, 64'h0, 6'd5, 1, 1, 1, 1, "R5");
    apply(4'd3, 64'h20, 64'hFFFF_FFFF_FFFF_FFC5, 6'd9, 0, 1, 0, 0, "R5");
    // R6 wrap, R7 upper word dropped, R8, R9 truncation
    apply(4'd6, '1, '1, 6'd0, 0, 0, 1, 0, "R6");
    apply(4'd9, 64'hDEAD_BEEF_FFFF_FFFF, 64'd1, 6'd0, 0, 0, 1, 1, "R7");
    apply(4'd10, 64'hFFFF_FFFF_FFFF_FFFF, '1, 6'd0, 0, 0, 1, 1, "R8");
    apply(4'd11, 64'h1234_5678_ABCD_EF01, 64'd0, 6'd40, 1, 0, 1, 1, "R9");
    apply(4'd11, 64'hFFFF_FFFF, 64'd0, 6'd0, 1, 0, 1, 1, "R9");
    // R10 R11 rejections
    apply(4'd2, '1, 64'd3, 6'd0, 0, 0, 1, 1, "R10");
    apply(4'd5, '1, 64'd3, 6'd0, 0, 1, 0, 1, "R10");
    apply(4'd7, '1, 64'd3, 6'd0, 0, 1, 1, 0, "R11");
    apply(4'd4, 64'd5, 64'd3, 6'd0, 0, 0, 1, 0, "R11");
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      apply(4'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, 6'($urandom),
            1'($urandom), ($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 4) != 0, "");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule